// File: doc/BRIEF.md
# Burst-Draining Converter Serial Writer

This block is a write-only serial master that feeds one digital-to-analog converter from a local word queue. A single start pulse begins a burst. The block takes one 24-bit word at a time from a first-word-fall-through FIFO and sends it as its own frame. It keeps doing this until the FIFO reports empty, then returns to idle. Each frame is enclosed by an active-low select line (`sync_n`). The serial clock idles high. Data is updated on rising clock edges, so the converter can sample on falling edges.

The pace of the serial clock is set by `HALF_DIV`, which is the number of system clock cycles in each half period of `sclk`. Each frame uses exactly `DATA_BITS` falling edges. No parity or padding bit is added. Between two frames of a burst, the select line returns high for one full serial clock period. The FIFO presents its head word on `fifo_data` whenever `fifo_empty` is low. A one-cycle `fifo_rd` pulse both captures that word and pops it.

Top module: `dac_spi_drain`

## Requirements
- R1: Every frame has exactly 24 falling edges of `sclk` while `sync_n` is low, and `sync_n` stays low for exactly 48*HALF_DIV clock cycles.
- R2: Bits go out most significant first. At the k-th falling edge of a frame (k = 1..24), `sdo` carries bit 24-k of the word.
- R3: While `sync_n` is low, `sdo` changes only in the cycle in which `sclk` rises. It never changes at a falling edge of `sclk`. While `sync_n` is high, `sdo` is 0.
- R4: `sclk` is high whenever `sync_n` is high. The first falling edge of a frame comes HALF_DIV cycles after `sync_n` falls, and `sclk` then toggles every HALF_DIV cycles.
- R5: Between consecutive frames of a burst, `sync_n` is high for exactly 2*HALF_DIV cycles.
- R6: `fifo_rd` is a single-cycle pulse, asserted only while `fifo_empty` is low. `sync_n` falls on the edge that ends the `fifo_rd` cycle, and the frame carries the word that `fifo_data` showed in that cycle.
- R7: After an accepted start, frames continue back to back until the FIFO is empty at the end of a gap. The number of frames equals the number of words queued.
- R8: A start pulse while idle with `fifo_empty` high is ignored. No `fifo_rd` occurs, `sync_n` stays high and `busy` stays low.
- R9: `busy` rises on the edge that accepts a start. It stays high while any frame is on the wire. It falls 2*HALF_DIV cycles after `sync_n` rises at the end of the last frame.
- R10: During reset, `sclk`=1, `sync_n`=1, `sdo`=0, `fifo_rd`=0 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a burst |
| fifo_empty | input | 1 | High when the FIFO holds no word |
| fifo_data | input | DATA_BITS | Head word of the FIFO (first-word-fall-through) |
| fifo_rd | output | 1 | One-cycle pop; the word is captured in the same cycle |
| sclk | output | 1 | Serial clock, idle high |
| sdo | output | 1 | Serial data, MSB first, stable at falling edges |
| sync_n | output | 1 | Active-low frame select |
| busy | output | 1 | High from accepted start until the final gap ends |

## Verification
The following are checked by assertions on every cycle:
- `sclk` is high whenever `sync_n` is high, and `sdo` holds still across each falling edge.
- `fifo_rd` pulses for only one cycle and never fires into an empty FIFO, and `sync_n` falls only right after a pop.
- Each frame counts out exactly 24 falling edges.
- The gap between frames is never shorter than a full serial period.
- An idle block facing an empty FIFO stays idle.

Only the directed scenarios can show the rest. These are the serial decoding of the words and their order, the exact low and gap lengths, the delay to the first falling edge, the frame count of a burst, and the exact `busy` tail.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  typedef enum logic [1:0] {
    DSD_IDLE  = 2'd0,
    DSD_SHIFT = 2'd1,
    DSD_GAP   = 2'd2
  } dsd_state_e;

  // number of sclk half periods in one frame
  function automatic int dsd_half_edges(input int bits);
    return 2 * bits;
  endfunction

  // clock cycles sync_n spends low for one frame
  function automatic int dsd_low_cycles(input int bits, input int half);
    return 2 * bits * half;
  endfunction

  // counter width able to hold 0..n-1, at least one bit
  function automatic int dsd_cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dsd_half_timer.sv
module dsd_half_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CW = dsd_pkg::dsd_cnt_width(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick = run && (cnt_q == LAST);

      // the divider never runs past its terminal count (R4 timing base)
      assert_div_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    end
  endgenerate

endmodule

// File: rtl/dsd_shifter.sv
module dsd_shifter #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] din,
  output logic             msb
);

  logic [WIDTH-1:0] sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sreg_q <= '0;
    else if (load)  sreg_q <= din;
    else if (shift) sreg_q <= {sreg_q[WIDTH-2:0], 1'b0};
  end

  assign msb = sreg_q[WIDTH-1];

  // a capture and a shift never coincide (R2 ordering)
  assert_load_shift_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !shift);

endmodule

// File: rtl/dsd_ctrl.sv
module dsd_ctrl #(
  parameter int BITS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fifo_empty,
  input  logic tick,
  output logic fifo_rd,
  output logic load,
  output logic shift,
  output logic run,
  output logic sclk,
  output logic sync_n,
  output logic busy
);
  import dsd_pkg::*;

  localparam int HALVES = dsd_half_edges(BITS);
  localparam int HW = dsd_cnt_width(HALVES);
  localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);
  localparam logic [HW-1:0] GAP_LAST = HW'(1);

  dsd_state_e state_q;
  logic [HW-1:0] half_q;
  logic sclk_q, sync_q;

  // named internal events
  logic pop_idle, gap_done, pop_gap, frame_end;

  assign pop_idle  = (state_q == DSD_IDLE) && start && !fifo_empty;
  assign gap_done  = (state_q == DSD_GAP) && tick && (half_q == GAP_LAST);
  assign pop_gap   = gap_done && !fifo_empty;
  assign frame_end = (state_q == DSD_SHIFT) && tick && (half_q == LAST_HALF);

  assign fifo_rd = pop_idle || pop_gap;
  assign load    = fifo_rd;
  assign shift   = (state_q == DSD_SHIFT) && tick && !sclk_q && !frame_end;
  assign run     = (state_q != DSD_IDLE);
  assign busy    = (state_q != DSD_IDLE);
  assign sclk    = sclk_q;
  assign sync_n  = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DSD_IDLE;
      half_q  <= '0;
      sclk_q  <= 1'b1;
      sync_q  <= 1'b1;
    end else begin
      case (state_q)
        DSD_IDLE: begin
          if (pop_idle) begin
            state_q <= DSD_SHIFT;
            sync_q  <= 1'b0;
            half_q  <= '0;
          end
        end
        DSD_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            if (frame_end) begin
              state_q <= DSD_GAP;
              sync_q  <= 1'b1;
              half_q  <= '0;
            end else begin
              half_q <= half_q + 1'b1;
            end
          end
        end
        DSD_GAP: begin
          if (tick) begin
            if (gap_done) begin
              half_q <= '0;
              if (pop_gap) begin
                state_q <= DSD_SHIFT;
                sync_q  <= 1'b0;
              end else begin
                state_q <= DSD_IDLE;
              end
            end else begin
              half_q <= half_q + 1'b1;
            end
          end
        end
        default: begin
          state_q <= DSD_IDLE;
          sync_q  <= 1'b1;
          sclk_q  <= 1'b1;
          half_q  <= '0;
        end
      endcase
    end
  end

  assert_rd_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> !fifo_rd);

  assert_rd_not_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  assert_frame_after_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> $past(fifo_rd));

  assert_sclk_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> sclk);

  assert_busy_covers_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> busy);

  assert_empty_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && fifo_empty) |=> (!busy && sync_n));

endmodule

// File: rtl/dac_spi_drain.sv
module dac_spi_drain #(
  parameter int DATA_BITS = 24,
  parameter int HALF_DIV  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 fifo_empty,
  input  logic [DATA_BITS-1:0] fifo_data,
  output logic                 fifo_rd,
  output logic                 sclk,
  output logic                 sdo,
  output logic                 sync_n,
  output logic                 busy
);

  logic tick, run, load, shift, msb;

  dsd_half_timer #(.HALF_DIV(HALF_DIV)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  dsd_ctrl #(.BITS(DATA_BITS)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fifo_empty (fifo_empty),
    .tick       (tick),
    .fifo_rd    (fifo_rd),
    .load       (load),
    .shift      (shift),
    .run        (run),
    .sclk       (sclk),
    .sync_n     (sync_n),
    .busy       (busy)
  );

  dsd_shifter #(.WIDTH(DATA_BITS)) shifter_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .shift (shift),
    .din   (fifo_data),
    .msb   (msb)
  );

  assign sdo = msb && !sync_n;

  // ---- checking logic: falling edges per frame and gap length ----
  localparam int FCW = $clog2(DATA_BITS + 2);
  localparam logic [15:0] MIN_GAP = 16'(2 * HALF_DIV);

  logic           sclk_d;
  logic [FCW-1:0] fall_cnt;
  logic [15:0]    gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b1;
      fall_cnt <= '0;
      gap_cnt  <= '0;
    end else begin
      sclk_d <= sclk;
      if (sync_n)               fall_cnt <= '0;
      else if (sclk_d && !sclk) fall_cnt <= fall_cnt + 1'b1;
      if (!sync_n)              gap_cnt <= '0;
      else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assert_frame_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> (fall_cnt == FCW'(DATA_BITS)));

  assert_sdo_stable_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> ($stable(sdo) && !sync_n));

  assert_sdo_quiet_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> !sdo);

  assert_gap_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync_n) && $past(busy)) |-> (gap_cnt >= MIN_GAP));

endmodule

// File: tb/dac_spi_drain_tb_top.sv
`timescale 1ns/1ps
module dac_spi_drain_tb_top;

  localparam int W = 24;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic fifo_empty;
  logic [W-1:0] fifo_data;
  logic fifo_rd, sclk, sdo, sync_n, busy;

  always #10 clk = ~clk;

  // FIFO model (first-word-fall-through)
  logic [W-1:0] fmem [0:63];
  logic [6:0] wr_ptr = '0;
  logic [6:0] rd_ptr = '0;
  assign fifo_empty = (wr_ptr == rd_ptr);
  assign fifo_data  = fmem[rd_ptr[5:0]];

  dac_spi_drain #(.DATA_BITS(W), .HALF_DIV(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_rd(fifo_rd), .sclk(sclk), .sdo(sdo),
    .sync_n(sync_n), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // read monitoring
  int rd_count, rd_double, rd_empty;
  logic rd_prev = 1'b0;
  always @(posedge clk) begin
    if (rst_n && fifo_rd) begin
      rd_count++;
      if (rd_prev) rd_double++;
      if (wr_ptr == rd_ptr) rd_empty++;
      rd_ptr <= rd_ptr + 7'd1;
    end
    rd_prev <= fifo_rd;
  end

  // wire monitor at falling clk edges
  int nframes, ngaps, sdo_bad, tail, low_len, high_len, since_rise, falls;
  int got_data [0:63];
  int got_falls[0:63];
  int got_low  [0:63];
  int got_first[0:63];
  int gaps     [0:63];
  logic [W-1:0] bits;
  int first_fall;
  logic p_sync = 1'b1, p_sclk = 1'b1, p_sdo = 1'b0, p_busy = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_sync && !sync_n) begin
        if (nframes > 0 && ngaps < 64) begin gaps[ngaps] = high_len; ngaps++; end
        low_len = 1; bits = '0; falls = 0; first_fall = -1;
      end else if (!sync_n) begin
        low_len++;
        if (p_sclk && !sclk) begin
          bits = {bits[W-2:0], sdo};
          falls++;
          if (first_fall < 0) first_fall = low_len - 1;
        end
      end else if (!p_sync && sync_n) begin
        if (nframes < 64) begin
          got_data[nframes] = int'(bits); got_falls[nframes] = falls;
          got_low[nframes] = low_len; got_first[nframes] = first_fall;
        end
        nframes++;
        high_len = 1;
        since_rise = 0;
      end else begin
        high_len++;
        since_rise++;
      end
      if (sdo !== p_sdo && !(!p_sclk && sclk) && !(p_sync !== sync_n)) sdo_bad++;
      if (sync_n && sdo) sdo_bad++;
      if (p_busy && !busy) tail = since_rise;
    end
    p_sync = sync_n; p_sclk = sclk; p_sdo = sdo; p_busy = busy;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    nframes = 0; ngaps = 0; sdo_bad = 0; tail = -1;
    rd_count = 0; rd_double = 0; rd_empty = 0;
  endtask

  task automatic push(input logic [W-1:0] w);
    fmem[wr_ptr[5:0]] = w;
    wr_ptr = wr_ptr + 7'd1;
  endtask

  bit busy_after;
  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    busy_after = busy;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(sclk == 1'b1, "R10 sclk in reset", int'(sclk), 1);
    check(sync_n == 1'b1, "R10 sync_n in reset", int'(sync_n), 1);
    check(sdo == 1'b0, "R10 sdo in reset", int'(sdo), 0);
    check(fifo_rd == 1'b0, "R10 fifo_rd in reset", int'(fifo_rd), 0);
    check(busy == 1'b0, "R10 busy in reset", int'(busy), 0);
  endtask

  task automatic test_empty_start();
    clear_mon();
    pulse_start();
    check(busy_after == 1'b0, "R8 busy after start on empty", int'(busy_after), 0);
    repeat (20) @(negedge clk);
    check(rd_count == 0, "R8 no pop on empty", rd_count, 0);
    check(nframes == 0 && sync_n, "R8 no frame on empty", nframes, 0);
    check(busy == 1'b0, "R8 still idle", int'(busy), 0);
  endtask

  int plan_w [0:63];
  task automatic run_burst(input string name, input int n);
    clear_mon();
    for (int i = 0; i < n; i++) push(plan_w[i][W-1:0]);
    pulse_start();
    check(busy_after == 1'b1, {"R9 busy on accept ", name}, int'(busy_after), 1);
    wait_idle();
    repeat (2) @(negedge clk);
    check(nframes == n, {"R7 frame count ", name}, nframes, n);
    for (int i = 0; i < n && i < 64; i++) begin
      check(got_data[i] == plan_w[i], {"R2 word value ", name}, got_data[i], plan_w[i]);
      check(got_falls[i] == W, {"R1 falling edges ", name}, got_falls[i], W);
      check(got_low[i] == 2*W*H, {"R1 sync_n low length ", name}, got_low[i], 2*W*H);
      check(got_first[i] == H, {"R4 first fall delay ", name}, got_first[i], H);
    end
    check(ngaps == n - 1, {"R5 gap count ", name}, ngaps, n - 1);
    for (int i = 0; i < ngaps; i++)
      check(gaps[i] == 2*H, {"R5 gap length ", name}, gaps[i], 2*H);
    check(rd_count == n, {"R6 pop count ", name}, rd_count, n);
    check(rd_double == 0 && rd_empty == 0, {"R6 pop pulse shape ", name}, rd_double + rd_empty, 0);
    check(sdo_bad == 0, {"R3 sdo timing ", name}, sdo_bad, 0);
    check(tail == 2*H, {"R9 busy tail ", name}, tail, 2*H);
    check(fifo_empty == 1'b1, {"R7 drained ", name}, int'(fifo_empty), 1);
  endtask

  task automatic test_single();
    plan_w[0] = 24'hA5C396;
    run_burst("single", 1);
  endtask

  task automatic test_patterns();
    plan_w[0] = 24'hFFFFFF; plan_w[1] = 24'h000000; plan_w[2] = 24'h555555;
    plan_w[3] = 24'h800001; plan_w[4] = 24'h000001;
    run_burst("patterns", 5);
  endtask

  task automatic test_full();
    for (int i = 0; i < 32; i++) plan_w[i] = ((i * 24'h010203) ^ 24'h5A3C81) & 24'hFFFFFF;
    run_burst("full32", 32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_empty_start();
    test_single();
    test_patterns();
    test_full();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule